// File: doc/BRIEF.md
# Image Sensor Operating-State Controller

This block sequences an image sensor through its power and operating states: a reset hold, low-power standby, a timed wake-up, configuration, idle and running. Each upward step waits a fixed number of clock cycles, so the analogue circuits and supplies have time to settle before the next step. Software selects a target state by writing a two-bit mode code. The controller then climbs one step at a time toward that target, or drops straight back down.

Frames can be started in two ways. Software can request continuous running, or an external trigger pin can be asserted and held. The trigger pin is resynchronised by a chain of flops, and a polarity input then selects whether a high or a low pin level counts as active. While running, the controller issues a one-cycle frame-start pulse for each frame. When each acquisition ends, it decides whether to capture another frame or to return to idle.

All delays are parameters measured in clock cycles. The defaults match microsecond-scale and tens-of-millisecond-scale waits at a moderate clock rate.

Top module: `sensor_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are forced at once to `state_o` = 0 (RESET), `busy` = 1 and `frame_start` = 0, and the target mode is cleared to 0.
- R2: Once `rst_n` is high, RESET is held for exactly `P_RST` rising edges. The state then becomes 1 (STANDBY).
- R3: A high `soft_rst` at a rising edge puts the state into RESET at that edge, from any state, and clears the target mode to 0. It takes priority over a mode write in the same cycle.
- R4: Mode codes on `mode_val` are taken when `mode_wr` is high: 0 = standby, 1 = config, 2 = idle, 3 = run. A write made while the state is RESET is discarded.
- R5: In STANDBY, a nonzero target moves the state to 2 (WAKE) at the edge of the write. WAKE lasts `P_WAKE` edges and is followed by 3 (CONFIG).
- R6: In CONFIG, a target of 2 or 3 must persist for `P_CFG` consecutive edges before the state becomes 4 (IDLE). A target of 1 keeps CONFIG indefinitely. A target of 0 returns to STANDBY at the next edge.
- R7: In IDLE, a run request (target 3, or an active trigger) that holds for `P_RUN` consecutive edges moves the state to 5 (RUN). `frame_start` pulses for one cycle, in the first RUN cycle. A request that lapses before then restarts the count.
- R8: The trigger is seen only after two flop stages, so a pin level sampled at edge k is first used at edge k+2. With `trig_act_low` = 0 a high pin is active; with `trig_act_low` = 1 a low pin is active.
- R9: In RUN, at an edge where `acq_done` is high, another one-cycle `frame_start` follows if the target is 3 or the trigger is active at that edge. Otherwise the state returns to IDLE. Without `acq_done`, RUN holds.
- R10: `busy` is high exactly in the RESET, WAKE and RUN states.
- R11: In IDLE, a target of 1 moves the state to CONFIG at the next edge, and a target of 0 moves it to STANDBY at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous command to re-enter RESET |
| mode_wr | input | 1 | Mode write strobe |
| mode_val | input | 2 | Requested mode code |
| trig_pin | input | 1 | Asynchronous external trigger |
| trig_act_low | input | 1 | 1 selects a low trigger level as active |
| acq_done | input | 1 | End-of-acquisition strobe for the current frame |
| state_o | output | 3 | Current state code |
| frame_start | output | 1 | One-cycle pulse at the start of each frame |
| busy | output | 1 | High in RESET, WAKE and RUN |

## Verification
Mode writes and soft reset act at the edge that samples them, so their effect is checked at the falling edge that follows. Timed steps take effect exactly `P_RST`, `P_WAKE`, `P_CFG` or `P_RUN` edges after the step's condition first holds. Trigger changes add two edges of synchroniser delay before that count starts, and `frame_start` appears in the same cycle as the RUN state it belongs to.

A behavioural model in the bench advances on every rising edge and is compared with all outputs at every falling edge. Directed checks sample one edge before and one edge after each expected transition, so an off-by-one delay is caught.

// File: rtl/smc_pkg.sv
package smc_pkg;

   typedef enum logic [2:0] {
      SMC_RESET   = 3'd0,
      SMC_STANDBY = 3'd1,
      SMC_WAKE    = 3'd2,
      SMC_CONFIG  = 3'd3,
      SMC_IDLE    = 3'd4,
      SMC_RUN     = 3'd5
   } smc_state_e;

   localparam int SMC_MODE_W = 2;

   localparam logic [SMC_MODE_W-1:0] MODE_STANDBY = 2'd0;
   localparam logic [SMC_MODE_W-1:0] MODE_CONFIG  = 2'd1;
   localparam logic [SMC_MODE_W-1:0] MODE_IDLE    = 2'd2;
   localparam logic [SMC_MODE_W-1:0] MODE_RUN     = 2'd3;

   function automatic int smc_max4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

   function automatic int smc_bits(input int v);
      if (v < 2) return 1;
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/smc_trig_sync.sv
module smc_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic act_low,
   output logic act
);

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b0;
      else        chain_q[0] <= pin;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b0;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   assign act = chain_q[STAGES-1] ^ act_low;

   if (STAGES == 2) begin : g_chk2
      logic [1:0] warm_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)              warm_q <= 2'd0;
         else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
      end
      // R8: the pin value two edges back is the one in use
      assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (warm_q == 2'd2) |-> (chain_q[1] == $past(pin, 2)));
   end

endmodule

// File: rtl/smc_delay_timer.sv
module smc_delay_timer #(
   parameter int          CNT_W   = 8,
   parameter logic [CNT_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= RST_VAL;
      else if (load)                  cnt_q <= load_val;
      else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/smc_mode_fsm.sv
module smc_mode_fsm
   import smc_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int P_RST  = 4,
   parameter int P_WAKE = 8,
   parameter int P_CFG  = 4,
   parameter int P_RUN  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  soft_rst,
   input  logic                  mode_wr,
   input  logic [SMC_MODE_W-1:0] mode_val,
   input  logic                  trig_act,
   input  logic                  acq_done,
   input  logic                  tmr_zero,
   output logic                  tmr_load,
   output logic [CNT_W-1:0]      tmr_val,
   output logic                  tmr_dec,
   output smc_state_e            state,
   output logic                  frame_start,
   output logic                  busy
);

   localparam logic [CNT_W-1:0] LD_RST  = CNT_W'(P_RST - 1);
   localparam logic [CNT_W-1:0] LD_WAKE = CNT_W'(P_WAKE - 1);
   localparam logic [CNT_W-1:0] LD_CFG  = CNT_W'(P_CFG - 1);
   localparam logic [CNT_W-1:0] LD_RUN  = CNT_W'(P_RUN - 1);

   smc_state_e            st_q, st_d;
   logic [SMC_MODE_W-1:0] tgt_q, tgt_eff;
   logic                  wr_ok, run_req, up_req;
   logic                  fs_d, fs_q, busy_q;

   assign wr_ok   = mode_wr && (st_q != SMC_RESET);
   assign tgt_eff = wr_ok ? mode_val : tgt_q;
   assign run_req = (tgt_eff == MODE_RUN) || trig_act;
   assign up_req  = (tgt_eff == MODE_IDLE) || (tgt_eff == MODE_RUN);

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      tmr_dec  = 1'b0;
      fs_d     = 1'b0;
      if (soft_rst) begin
         st_d     = SMC_RESET;
         tmr_load = 1'b1;
         tmr_val  = LD_RST;
      end else begin
         unique case (st_q)
            SMC_RESET: begin
               if (tmr_zero) st_d = SMC_STANDBY;
               else          tmr_dec = 1'b1;
            end
            SMC_STANDBY: begin
               if (tgt_eff != MODE_STANDBY) begin
                  st_d     = SMC_WAKE;
                  tmr_load = 1'b1;
                  tmr_val  = LD_WAKE;
               end
            end
            SMC_WAKE: begin
               if (tmr_zero) begin
                  st_d     = SMC_CONFIG;
                  tmr_load = 1'b1;
                  tmr_val  = LD_CFG;
               end else begin
                  tmr_dec = 1'b1;
               end
            end
            SMC_CONFIG: begin
               if (tgt_eff == MODE_STANDBY) begin
                  st_d = SMC_STANDBY;
               end else if (up_req) begin
                  if (tmr_zero) begin
                     st_d     = SMC_IDLE;
                     tmr_load = 1'b1;
                     tmr_val  = LD_RUN;
                  end else begin
                     tmr_dec = 1'b1;
                  end
               end else begin
                  tmr_load = 1'b1;
                  tmr_val  = LD_CFG;
               end
            end
            SMC_IDLE: begin
               if (tgt_eff == MODE_STANDBY) begin
                  st_d = SMC_STANDBY;
               end else if (tgt_eff == MODE_CONFIG) begin
                  st_d     = SMC_CONFIG;
                  tmr_load = 1'b1;
                  tmr_val  = LD_CFG;
               end else if (run_req) begin
                  if (tmr_zero) begin
                     st_d = SMC_RUN;
                     fs_d = 1'b1;
                  end else begin
                     tmr_dec = 1'b1;
                  end
               end else begin
                  tmr_load = 1'b1;
                  tmr_val  = LD_RUN;
               end
            end
            SMC_RUN: begin
               if (acq_done) begin
                  if (run_req) begin
                     fs_d = 1'b1;
                  end else begin
                     st_d     = SMC_IDLE;
                     tmr_load = 1'b1;
                     tmr_val  = LD_RUN;
                  end
               end
            end
            default: begin
               st_d     = SMC_RESET;
               tmr_load = 1'b1;
               tmr_val  = LD_RST;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SMC_RESET;
         tgt_q  <= MODE_STANDBY;
         fs_q   <= 1'b0;
         busy_q <= 1'b1;
      end else begin
         st_q   <= st_d;
         fs_q   <= fs_d;
         busy_q <= (st_d == SMC_RESET) || (st_d == SMC_WAKE) || (st_d == SMC_RUN);
         if (soft_rst)   tgt_q <= MODE_STANDBY;
         else if (wr_ok) tgt_q <= mode_val;
      end
   end

   assign state       = st_q;
   assign frame_start = fs_q;
   assign busy        = busy_q;

   // R3: soft reset wins at the sampling edge
   assert_soft_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (st_q == SMC_RESET));

   // R2: RESET can only be left toward STANDBY
   assert_reset_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SMC_RESET && !soft_rst) |=> (st_q == SMC_RESET || st_q == SMC_STANDBY));

   // R5: WAKE can only be left toward CONFIG
   assert_wake_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SMC_WAKE && !soft_rst) |=> (st_q == SMC_WAKE || st_q == SMC_CONFIG));

   // R7: a frame pulse only appears in RUN
   assert_frame_in_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (st_q == SMC_RUN));

   // R9: without an end of acquisition RUN holds and no new frame starts
   assert_run_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SMC_RUN && !acq_done && !soft_rst) |=> (st_q == SMC_RUN && !frame_start));

endmodule

// File: rtl/sensor_mode_ctrl.sv
module sensor_mode_ctrl
   import smc_pkg::*;
#(
   parameter int P_RST       = 100,
   parameter int P_WAKE      = 2500000,
   parameter int P_CFG       = 1750,
   parameter int P_RUN       = 2500,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       soft_rst,
   input  logic       mode_wr,
   input  logic [1:0] mode_val,
   input  logic       trig_pin,
   input  logic       trig_act_low,
   input  logic       acq_done,
   output logic [2:0] state_o,
   output logic       frame_start,
   output logic       busy
);

   localparam int MAX_DLY = smc_max4(P_RST, P_WAKE, P_CFG, P_RUN);
   localparam int CNT_W   = smc_bits(MAX_DLY - 1);
   localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(P_RST - 1);

   initial begin
      assert (P_RST >= 1)       else $error("P_RST must be at least 1");
      assert (P_WAKE >= 1)      else $error("P_WAKE must be at least 1");
      assert (P_CFG >= 1)       else $error("P_CFG must be at least 1");
      assert (P_RUN >= 1)       else $error("P_RUN must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic             trig_act;
   logic             tmr_zero, tmr_load, tmr_dec;
   logic [CNT_W-1:0] tmr_val;
   smc_state_e       st;

   smc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (trig_pin),
      .act_low (trig_act_low),
      .act     (trig_act)
   );

   smc_delay_timer #(.CNT_W(CNT_W), .RST_VAL(CNT_RST)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .dec      (tmr_dec),
      .zero     (tmr_zero)
   );

   smc_mode_fsm #(
      .CNT_W  (CNT_W),
      .P_RST  (P_RST),
      .P_WAKE (P_WAKE),
      .P_CFG  (P_CFG),
      .P_RUN  (P_RUN)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .soft_rst    (soft_rst),
      .mode_wr     (mode_wr),
      .mode_val    (mode_val),
      .trig_act    (trig_act),
      .acq_done    (acq_done),
      .tmr_zero    (tmr_zero),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .tmr_dec     (tmr_dec),
      .state       (st),
      .frame_start (frame_start),
      .busy        (busy)
   );

   assign state_o = st;

endmodule

// File: tb/sensor_mode_ctrl_tb.sv
`timescale 1ns/1ps
module sensor_mode_ctrl_tb;

   localparam int T_RST  = 3;
   localparam int T_WAKE = 6;
   localparam int T_CFG  = 4;
   localparam int T_RUN  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       mode_wr = 1'b0;
   logic [1:0] mode_val = 2'd0;
   logic       trig_pin = 1'b0;
   logic       trig_act_low = 1'b0;
   logic       acq_done = 1'b0;
   logic [2:0] state_o;
   logic       frame_start;
   logic       busy;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #2 clk = ~clk;

   sensor_mode_ctrl #(
      .P_RST(T_RST), .P_WAKE(T_WAKE), .P_CFG(T_CFG), .P_RUN(T_RUN), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode_wr(mode_wr),
      .mode_val(mode_val), .trig_pin(trig_pin), .trig_act_low(trig_act_low),
      .acq_done(acq_done), .state_o(state_o), .frame_start(frame_start), .busy(busy)
   );

   // behavioural reference: 0 RESET,1 STANDBY,2 WAKE,3 CONFIG,4 IDLE,5 RUN
   int m_st = 0, m_tgt = 0, m_age = 0, m_fs = 0;
   bit tq[$] = '{1'b0, 1'b0};

   always @(posedge clk) begin
      int eff;
      bit act;
      if (!rst_n) begin
         m_st = 0; m_tgt = 0; m_age = 0; m_fs = 0;
         tq = '{1'b0, 1'b0};
      end else begin
         act = tq[0] ^ trig_act_low;
         void'(tq.pop_front());
         tq.push_back(trig_pin);
         eff = (mode_wr && m_st != 0) ? int'(mode_val) : m_tgt;
         m_fs = 0;
         if (soft_rst) begin
            m_st = 0; m_tgt = 0; m_age = 0;
         end else begin
            m_tgt = eff;
            case (m_st)
               0: begin m_age++; if (m_age == T_RST) begin m_st = 1; m_age = 0; end end
               1: if (eff != 0) begin m_st = 2; m_age = 0; end
               2: begin m_age++; if (m_age == T_WAKE) begin m_st = 3; m_age = 0; end end
               3: begin
                  if (eff == 0) begin m_st = 1; m_age = 0; end
                  else if (eff >= 2) begin
                     m_age++;
                     if (m_age == T_CFG) begin m_st = 4; m_age = 0; end
                  end else m_age = 0;
               end
               4: begin
                  if (eff == 0) begin m_st = 1; m_age = 0; end
                  else if (eff == 1) begin m_st = 3; m_age = 0; end
                  else if (eff == 3 || act) begin
                     m_age++;
                     if (m_age == T_RUN) begin m_st = 5; m_fs = 1; m_age = 0; end
                  end else m_age = 0;
               end
               default: begin
                  if (acq_done) begin
                     if (eff == 3 || act) m_fs = 1;
                     else begin m_st = 4; m_age = 0; end
                  end
               end
            endcase
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         int m_busy;
         m_busy = (m_st == 0 || m_st == 2 || m_st == 5) ? 1 : 0;
         checks++;
         if (int'(state_o) != m_st) begin
            errors++;
            $display("FAIL model state (R2 R5 R6 R7 R9 R11) actual=%0d expected=%0d", state_o, m_st);
         end
         checks++;
         if (int'(frame_start) != m_fs) begin
            errors++;
            $display("FAIL model frame_start (R7 R9) actual=%0d expected=%0d", frame_start, m_fs);
         end
         checks++;
         if (int'(busy) != m_busy) begin
            errors++;
            $display("FAIL model busy (R10) actual=%0d expected=%0d", busy, m_busy);
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr_mode(input logic [1:0] v);
      mode_wr = 1'b1; mode_val = v;
      step(1);
      mode_wr = 1'b0;
   endtask

   task automatic pulse_acq();
      acq_done = 1'b1;
      step(1);
      acq_done = 1'b0;
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      step(3);
      chk("R1 state in reset", int'(state_o), 0);
      chk("R1 busy in reset", int'(busy), 1);
      chk("R1 frame_start in reset", int'(frame_start), 0);
      rst_n = 1'b1;
      step(2);
      chk("R2 still RESET", int'(state_o), 0);
      step(1);
      chk("R2 STANDBY after delay", int'(state_o), 1);

      soft_rst = 1'b1; step(1); soft_rst = 1'b0;
      chk("R3 soft reset", int'(state_o), 0);
      wr_mode(2'd3);
      step(5);
      chk("R4 write in RESET dropped", int'(state_o), 1);

      wr_mode(2'd3);
      chk("R5 enter WAKE", int'(state_o), 2);
      chk("R10 busy in WAKE", int'(busy), 1);
      step(5);
      chk("R5 still WAKE", int'(state_o), 2);
      step(1);
      chk("R5 CONFIG after wake", int'(state_o), 3);
      chk("R10 busy low in CONFIG", int'(busy), 0);
      step(3);
      chk("R6 still CONFIG", int'(state_o), 3);
      step(1);
      chk("R6 IDLE after config delay", int'(state_o), 4);
      step(1);
      chk("R7 still IDLE", int'(state_o), 4);
      step(1);
      chk("R7 RUN", int'(state_o), 5);
      chk("R7 frame_start", int'(frame_start), 1);
      chk("R10 busy in RUN", int'(busy), 1);
      step(1);
      chk("R7 frame_start one cycle", int'(frame_start), 0);

      pulse_acq();
      chk("R9 register mode refire", int'(frame_start), 1);
      step(1);
      wr_mode(2'd2);
      chk("R9 write does not leave RUN", int'(state_o), 5);
      pulse_acq();
      chk("R9 back to IDLE", int'(state_o), 4);
      chk("R9 no frame on exit", int'(frame_start), 0);

      trig_pin = 1'b1;
      step(3);
      chk("R8 sync latency IDLE", int'(state_o), 4);
      step(1);
      chk("R8 trigger start RUN", int'(state_o), 5);
      chk("R8 trigger frame_start", int'(frame_start), 1);
      step(1);
      pulse_acq();
      chk("R9 held trigger refire", int'(frame_start), 1);
      trig_pin = 1'b0;
      step(2);
      pulse_acq();
      chk("R9 released trigger to IDLE", int'(state_o), 4);

      wr_mode(2'd1);
      chk("R11 IDLE to CONFIG", int'(state_o), 3);
      trig_act_low = 1'b1; trig_pin = 1'b1;
      step(6);
      chk("R6 target 1 holds CONFIG", int'(state_o), 3);
      wr_mode(2'd2);
      chk("R6 CONFIG counting", int'(state_o), 3);
      step(2);
      chk("R6 CONFIG counting late", int'(state_o), 3);
      step(1);
      chk("R6 IDLE", int'(state_o), 4);
      step(6);
      chk("R8 high pin inactive when active-low", int'(state_o), 4);
      trig_pin = 1'b0;
      step(3);
      chk("R8 active-low latency", int'(state_o), 4);
      step(1);
      chk("R8 active-low start", int'(state_o), 5);
      trig_pin = 1'b1;
      step(2);
      pulse_acq();
      chk("R9 inactive at end to IDLE", int'(state_o), 4);

      trig_pin = 1'b0; step(1); trig_pin = 1'b1;
      step(6);
      chk("R7 short request restarts count", int'(state_o), 4);

      wr_mode(2'd0);
      chk("R11 IDLE to STANDBY", int'(state_o), 1);
      wr_mode(2'd1);
      chk("R5 WAKE again", int'(state_o), 2);
      step(6);
      chk("R5 CONFIG again", int'(state_o), 3);
      wr_mode(2'd0);
      chk("R6 CONFIG to STANDBY", int'(state_o), 1);

      soft_rst = 1'b1; mode_wr = 1'b1; mode_val = 2'd3;
      step(1);
      soft_rst = 1'b0; mode_wr = 1'b0;
      chk("R3 soft reset beats write", int'(state_o), 0);
      step(5);
      chk("R3 target cleared", int'(state_o), 1);

      step(2);
      finish_run();
   end

   initial begin
      step(20000);
      if (!done_flag) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         finish_run();
      end
   end

endmodule